// File: doc/BRIEF.md
# Generic transmit checksum inserter

This block sits in a transmit path and fills in a 16-bit one's-complement checksum in each outgoing frame without parsing any protocol header. Each frame enters as a byte stream with valid/ready handshaking and a last-byte marker. A 16-bit control word travels alongside the first byte of the frame. The control word carries three fields: where the summation begins, where the result is written back, and a type code that selects insertion or plain pass-through.

The whole frame is stored internally. The checksum builds up byte by byte as the frame arrives, so one cycle after the last byte the complemented result is known. The stored frame is then streamed out, and the two result bytes replace the buffered contents at the insertion point. A frame whose insertion point would run past its end leaves unmodified, and an error flag stays high for every byte of it.

Top module: `csum_insert_top`

## Requirements
- R1: After reset, the output is idle (`m_tvalid` = 0, `m_err` = 0) and the input is ready (`s_tready` = 1).
- R2: Control bits 14:12 form the type code. Only value 1 enables insertion. With any other value the frame leaves byte for byte as it entered, with `m_err` = 0.
- R3: Control bits 7:0 give the summation start in 2-byte units, counted from the first byte of the frame.
- R4: Control bits 11:8 give the insertion point in 2-byte units, counted from the summation start. The complemented sum is written there, high byte first.
- R5: The sum pairs bytes big-endian (the byte at an even distance from the start is the high byte) and folds end-around carries. It covers every byte from the start to the end of the frame, including whatever the checksum field already holds.
- R6: When an odd number of bytes is summed, a zero low byte is assumed after the last one. The frame leaves with exactly as many bytes as it entered.
- R7: The first output byte appears only after the last input byte has been accepted. `s_tready` is low whenever `m_tvalid` is high.
- R8: With type 1, if the insertion point plus two bytes extends past the frame end, the frame leaves unmodified with `m_err` high on all of its bytes. Otherwise `m_err` is low. An insertion ending exactly on the last byte is valid.
- R9: The control word is taken only with the first byte of a frame. Its value on later bytes has no effect. Frames may follow each other directly, and each one uses its own control word.
- R10: While `m_tvalid` is high and `m_tready` is low, `m_tdata`, `m_tlast` and `m_tvalid` hold.
- R11: Frames up to the buffer depth (2048 bytes by default) are carried in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | 8 | Input frame byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Block accepts an input byte |
| s_tlast | input | 1 | Input byte is the last of its frame |
| s_ctrl | input | 16 | Per-frame control word, taken with the first byte |
| m_tdata | output | 8 | Output frame byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Downstream accepts an output byte |
| m_tlast | output | 1 | Output byte is the last of its frame |
| m_err | output | 1 | Insertion point out of range for the current output frame |

## Verification
The hardest case to reach is a control word that changes while a frame is still arriving, while a second frame waits to enter as soon as the first has drained. If the block latched the wrong copy of the word, its checksum would still look plausible. The bench drives frames back to back and puts a different control value on every byte after the first, including one whose type field would disable insertion. The output of each frame is then compared with a model that uses only that frame's first-byte control word. Range-edge frames are also included: one whose checksum field ends exactly on the final byte, and one a single byte too short.

// File: rtl/csum_pkg.sv
package csum_pkg;

  localparam int CTRL_W    = 16;
  localparam int START_LSB = 0;
  localparam int START_W   = 8;
  localparam int INS_LSB   = 8;
  localparam int INS_W     = 4;
  localparam int TYPE_LSB  = 12;
  localparam int TYPE_W    = 3;

  localparam logic [TYPE_W-1:0] TYPE_INSERT = 3'd1;

  typedef enum logic [1:0] {
    PH_FILL  = 2'd0,
    PH_SEAL  = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;

  // one's-complement 16-bit addition with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] raw;
    raw = {1'b0, a} + {1'b0, b};
    return raw[15:0] + {15'd0, raw[16]};
  endfunction

endpackage

// File: rtl/csum_field_dec.sv
module csum_field_dec
  import csum_pkg::*;
#(
  parameter int LW = 12
) (
  input  logic [CTRL_W-1:0] ctrl,
  output logic [LW-1:0]     start_off,
  output logic [LW-1:0]     ins_off,
  output logic              insert_en
);

  logic [START_W:0] start_bytes;
  logic [INS_W:0]   rel_bytes;

  always_comb begin
    start_bytes = {ctrl[START_LSB +: START_W], 1'b0};
    rel_bytes   = {ctrl[INS_LSB +: INS_W], 1'b0};
    start_off   = LW'(start_bytes);
    ins_off     = start_off + LW'(rel_bytes);
    insert_en   = (ctrl[TYPE_LSB +: TYPE_W] == TYPE_INSERT);
  end

endmodule

// File: rtl/csum_ones_acc.sv
module csum_ones_acc
  import csum_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic        restart,
  input  logic        incl,
  input  logic        hi_lane,
  input  logic [7:0]  data,
  output logic [15:0] sum
);

  logic [15:0] sum_q, sum_d, base, word;

  always_comb begin
    word  = hi_lane ? {data, 8'h00} : {8'h00, data};
    base  = restart ? 16'h0000 : sum_q;
    sum_d = sum_q;
    if (step) begin
      sum_d = incl ? oc_add(base, word) : base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= 16'h0000;
    end else if (step) begin
      sum_q <= sum_d;
    end
  end

  assign sum = sum_q;

  // R5
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(sum_q));

endmodule

// File: rtl/csum_pkt_buf.sv
module csum_pkt_buf #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/csum_insert_top.sv
module csum_insert_top
  import csum_pkg::*;
#(
  parameter int BUF_DEPTH = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  s_tdata,
  input  logic        s_tvalid,
  output logic        s_tready,
  input  logic        s_tlast,
  input  logic [15:0] s_ctrl,
  output logic [7:0]  m_tdata,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic        m_tlast,
  output logic        m_err
);

  localparam int AW = $clog2(BUF_DEPTH);
  localparam int LW = AW + 1;
  localparam logic [LW-1:0] FULL_CNT = LW'(BUF_DEPTH);

  phase_e            phase_q, phase_d;
  logic [LW-1:0]     wr_cnt_q, wr_cnt_d;
  logic [LW-1:0]     rd_ptr_q, rd_ptr_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [15:0]       csum_q, csum_d;
  logic [LW-1:0]     ins_q, ins_d;
  logic              patch_q, patch_d;
  logic              err_q, err_d;

  logic              first_byte;
  logic [CTRL_W-1:0] ctrl_cur;
  logic [LW-1:0]     start_off, ins_off;
  logic              insert_en;
  logic              in_fire, out_fire;
  logic              incl, hi_lane, fits;
  logic [15:0]       run_sum;
  logic [7:0]        buf_byte;

  assign first_byte = (wr_cnt_q == '0);
  assign ctrl_cur   = first_byte ? s_ctrl : ctrl_q;

  csum_field_dec #(.LW(LW)) dec_i (
    .ctrl      (ctrl_cur),
    .start_off (start_off),
    .ins_off   (ins_off),
    .insert_en (insert_en)
  );

  assign s_tready = (phase_q == PH_FILL) && (wr_cnt_q != FULL_CNT);
  assign in_fire  = s_tvalid && s_tready;
  assign m_tvalid = (phase_q == PH_DRAIN);
  assign out_fire = m_tvalid && m_tready;

  // start offset is always even, so the lane follows the byte count parity
  assign incl    = (wr_cnt_q >= start_off);
  assign hi_lane = ~wr_cnt_q[0];

  csum_ones_acc acc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (in_fire),
    .restart (first_byte),
    .incl    (incl),
    .hi_lane (hi_lane),
    .data    (s_tdata),
    .sum     (run_sum)
  );

  csum_pkt_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) buf_i (
    .clk     (clk),
    .wr_en   (in_fire),
    .wr_addr (wr_cnt_q[AW-1:0]),
    .wr_data (s_tdata),
    .rd_addr (rd_ptr_q[AW-1:0]),
    .rd_data (buf_byte)
  );

  assign fits = ({1'b0, ins_off} + (LW+1)'(2)) <= {1'b0, wr_cnt_q};

  always_comb begin
    phase_d  = phase_q;
    wr_cnt_d = wr_cnt_q;
    rd_ptr_d = rd_ptr_q;
    ctrl_d   = ctrl_q;
    csum_d   = csum_q;
    ins_d    = ins_q;
    patch_d  = patch_q;
    err_d    = err_q;
    unique case (phase_q)
      PH_FILL: begin
        if (in_fire) begin
          wr_cnt_d = wr_cnt_q + LW'(1);
          if (first_byte) ctrl_d = s_ctrl;
          if (s_tlast) phase_d = PH_SEAL;
        end
      end
      PH_SEAL: begin
        csum_d   = ~run_sum;
        ins_d    = ins_off;
        patch_d  = insert_en && fits;
        err_d    = insert_en && !fits;
        rd_ptr_d = '0;
        phase_d  = PH_DRAIN;
      end
      PH_DRAIN: begin
        if (out_fire) begin
          if (m_tlast) begin
            phase_d  = PH_FILL;
            wr_cnt_d = '0;
          end else begin
            rd_ptr_d = rd_ptr_q + LW'(1);
          end
        end
      end
      default: phase_d = PH_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_FILL;
      wr_cnt_q <= '0;
      rd_ptr_q <= '0;
      ctrl_q   <= '0;
      csum_q   <= '0;
      ins_q    <= '0;
      patch_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      wr_cnt_q <= wr_cnt_d;
      rd_ptr_q <= rd_ptr_d;
      ctrl_q   <= ctrl_d;
      csum_q   <= csum_d;
      ins_q    <= ins_d;
      patch_q  <= patch_d;
      err_q    <= err_d;
    end
  end

  always_comb begin
    m_tdata = buf_byte;
    if (patch_q && (rd_ptr_q == ins_q)) begin
      m_tdata = csum_q[15:8];
    end else if (patch_q && (rd_ptr_q == ins_q + LW'(1))) begin
      m_tdata = csum_q[7:0];
    end
  end

  assign m_tlast = m_tvalid && (rd_ptr_q == wr_cnt_q - LW'(1));
  assign m_err   = m_tvalid && err_q;

  // R7
  drain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> !s_tready);

  // R7
  last_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tlast) |=> !s_tready);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  // R8
  err_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && !m_tlast) |=> (m_tvalid && $stable(m_err)));

endmodule

// File: tb/csum_insert_top_tb.sv
module csum_insert_top_tb_top;

  localparam int MAXB = 2048;

  logic        clk;
  logic        rst_n;
  logic [7:0]  s_tdata;
  logic        s_tvalid;
  logic        s_tready;
  logic        s_tlast;
  logic [15:0] s_ctrl;
  logic [7:0]  m_tdata;
  logic        m_tvalid;
  logic        m_tready;
  logic        m_tlast;
  logic        m_err;

  int n_chk;
  int n_bad;
  int cyc;

  logic [7:0]  pin  [2][MAXB];
  int          plen [2];
  logic [15:0] pctl [2];
  logic [7:0]  pout [2][MAXB];
  int          olen [2];
  logic        oerr [2];
  logic        err_wobble;
  logic [7:0]  pexp [MAXB];
  logic        exp_err;
  logic        early_seen;
  logic        overlap_seen;

  csum_insert_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_tdata  (s_tdata),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .s_tlast  (s_tlast),
    .s_ctrl   (s_ctrl),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tlast  (m_tlast),
    .m_err    (m_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int k, input int len, input int seed);
    plen[k] = len;
    for (int i = 0; i < len; i++) pin[k][i] = 8'((seed * 37) + (i * 13) + (i >> 3));
  endtask

  task automatic build_exp(input int k);
    int unsigned s;
    int sb, ib, len;
    logic [15:0] c;
    len = plen[k];
    sb  = int'(pctl[k][7:0]) * 2;
    ib  = sb + int'(pctl[k][11:8]) * 2;
    for (int i = 0; i < len; i++) pexp[i] = pin[k][i];
    s = 0;
    for (int i = sb; i < len; i += 2) s += {pin[k][i], (i + 1 < len) ? pin[k][i+1] : 8'h00};
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
    c = ~s[15:0];
    exp_err = 1'b0;
    if (pctl[k][14:12] == 3'd1) begin
      if (ib + 2 <= len) begin
        pexp[ib]   = c[15:8];
        pexp[ib+1] = c[7:0];
      end else begin
        exp_err = 1'b1;
      end
    end
  endtask

  task automatic send_all(input int n, input bit junk);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < plen[k]; i++) begin
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata  = pin[k][i];
        s_tlast  = (i == plen[k] - 1);
        s_ctrl   = (i == 0 || !junk) ? pctl[k] : (16'h5A5A ^ 16'(i * 7));
        while (!s_tready) @(negedge clk);
        if (m_tvalid) early_seen = 1'b1;
      end
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic recv_all(input int n, input bit stall);
    for (int k = 0; k < n; k++) begin
      int idx;
      bit done;
      bit rdy;
      idx = 0;
      done = 0;
      while (!done) begin
        @(negedge clk);
        rdy = stall ? ((cyc % 3) != 1) : 1'b1;
        m_tready = rdy;
        if (m_tvalid && s_tready) overlap_seen = 1'b1;
        if (m_tvalid && rdy) begin
          if (idx < MAXB) pout[k][idx] = m_tdata;
          if (idx == 0) oerr[k] = m_err;
          else if (m_err != oerr[k]) err_wobble = 1'b1;
          idx++;
          if (m_tlast) done = 1;
        end
      end
      olen[k] = idx;
    end
    @(negedge clk);
    m_tready = 1'b0;
  endtask

  task automatic run(input int n, input bit stall, input bit junk);
    early_seen   = 1'b0;
    overlap_seen = 1'b0;
    err_wobble   = 1'b0;
    fork
      send_all(n, junk);
      recv_all(n, stall);
    join
    chk(!early_seen, "R7", "output before last input byte", int'(early_seen), 0);
    chk(!overlap_seen, "R7", "s_tready while draining", int'(overlap_seen), 0);
    chk(!err_wobble, "R8", "m_err changed inside frame", int'(err_wobble), 0);
  endtask

  task automatic compare(input int k, input string req);
    int bad_at;
    build_exp(k);
    chk(olen[k] == plen[k], req, "frame length", olen[k], plen[k]);
    chk(oerr[k] == exp_err, req, "m_err", int'(oerr[k]), int'(exp_err));
    bad_at = -1;
    for (int i = 0; i < plen[k] && i < olen[k]; i++)
      if (bad_at < 0 && pout[k][i] !== pexp[i]) bad_at = i;
    if (bad_at >= 0)
      chk(1'b0, req, $sformatf("byte %0d", bad_at), int'(pout[k][bad_at]), int'(pexp[bad_at]));
    else
      chk(1'b1, req, "payload", 0, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(m_tvalid == 1'b0, "R1", "m_tvalid after reset", int'(m_tvalid), 0);
    chk(s_tready == 1'b1, "R1", "s_tready after reset", int'(s_tready), 1);
    chk(m_err == 1'b0, "R1", "m_err after reset", int'(m_err), 0);
  endtask

  task automatic t_known();
    logic [7:0] v [10];
    v = '{8'h00, 8'h01, 8'hF2, 8'h03, 8'hF4, 8'hF5, 8'hF6, 8'hF7, 8'h00, 8'h00};
    plen[0] = 10;
    for (int i = 0; i < 10; i++) pin[0][i] = v[i];
    pctl[0] = 16'h1400;
    run(1, 0, 0);
    chk(pout[0][8] == 8'h22, "R5", "known sum high byte", int'(pout[0][8]), 'h22);
    chk(pout[0][9] == 8'h0D, "R4", "known sum low byte", int'(pout[0][9]), 'h0D);
    compare(0, "R5");
  endtask

  task automatic t_passthru();
    logic [15:0] codes [3];
    codes = '{16'h0203, 16'h3203, 16'h7203};
    for (int c = 0; c < 3; c++) begin
      fill(0, 40 + c, c + 3);
      pctl[0] = codes[c];
      run(1, 0, 0);
      compare(0, "R2");
    end
  endtask

  task automatic t_offsets();
    fill(0, 61, 9);
    pctl[0] = 16'h1307;
    run(1, 0, 0);
    compare(0, "R3");
    compare(0, "R6");
    fill(0, 64, 11);
    pctl[0] = 16'h1000;
    run(1, 0, 0);
    compare(0, "R4");
  endtask

  task automatic t_range();
    fill(0, 30, 5);
    pctl[0] = 16'h140A;
    run(1, 0, 0);
    compare(0, "R8");
    chk(oerr[0] == 1'b0, "R8", "exact-fit m_err", int'(oerr[0]), 0);
    fill(0, 29, 5);
    run(1, 0, 0);
    compare(0, "R8");
    chk(oerr[0] == 1'b1, "R8", "overrun m_err", int'(oerr[0]), 1);
    fill(0, 40, 6);
    pctl[0] = 16'h10C8;
    run(1, 0, 0);
    compare(0, "R8");
  endtask

  task automatic t_b2b();
    fill(0, 50, 21);
    pctl[0] = 16'h1205;
    fill(1, 33, 22);
    pctl[1] = 16'h1101;
    run(2, 0, 1);
    compare(0, "R9");
    compare(1, "R9");
  endtask

  task automatic t_stall();
    fill(0, 100, 31);
    pctl[0] = 16'h1A10;
    run(1, 1, 0);
    compare(0, "R10");
  endtask

  task automatic t_long();
    fill(0, 1500, 41);
    pctl[0] = 16'h1F20;
    run(1, 0, 0);
    compare(0, "R11");
    fill(0, MAXB, 43);
    pctl[0] = 16'h1100;
    run(1, 1, 0);
    compare(0, "R11");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    cyc = 0;
    rst_n = 1'b0;
    s_tdata = '0;
    s_tvalid = 1'b0;
    s_tlast = 1'b0;
    s_ctrl = '0;
    m_tready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_known();
    t_passthru();
    t_offsets();
    t_range();
    t_b2b();
    t_stall();
    t_long();
    finish_run();
  end

  initial begin
    wait (cyc > 150000);
    chk(1'b0, "R7", "watchdog expired", cyc, 150000);
    finish_run();
  end

endmodule